// File: doc/BRIEF.md
# Aliased Set/Clear Reset Control Register

This block holds one 32-bit control word. Each of its low 26 bits drives an active-low reset line to one shared sub-block. Software writes the word through a small register bus. The bus offers four word aliases that share the same storage. The first alias loads the word as written. The second alias releases the blocks whose bits are written as one. The third alias places the blocks whose bits are written as one into reset. The fourth alias discards writes. A read from any alias returns the current word, where a one means the block is running.

The line assignment is as follows. Line 0 is the network top block. Lines 1-4 are MAC 0-3. Lines 5-8 are gigabit PCS 0-3. Lines 9-16 are high-speed PCS 0-7. Lines 17-20 are transmit lanes 0-3. Lines 21-24 are receive lanes 0-3. Line 25 is the SerDes glue block. Only the management-domain reset `mgmt_rst` clears the word, and the block has no other reset input. The block does not bridge bus protocols, and it does not synchronise resets inside the target blocks.

Top module: `rst_alias_ctrl`

## Requirements
- R1: While `mgmt_rst` is high, the word is cleared on the next clock edge. After that edge every `blk_rst_n` line is 0 and a read returns 0.
- R2: A read (`bus_sel`=1, `bus_wr`=0) taken on a clock edge loads `bus_rdata` on that same edge with the word as it stood before the edge. The value is the same for all four `bus_waddr` values, and bit i set to 1 means line i is released.
- R3: A write with `bus_waddr`=0 replaces bits 25:0 with `bus_wdata[25:0]`.
- R4: A write with `bus_waddr`=1 sets to 1 every bit written as 1. Bits written as 0 keep their value.
- R5: A write with `bus_waddr`=2 clears to 0 every bit written as 1. Bits written as 0 keep their value.
- R6: A write with `bus_waddr`=3 leaves the word and every `blk_rst_n` line unchanged.
- R7: Line `blk_rst_n[i]` follows word bit i only. Writing a single bit changes exactly that one line.
- R8: Bits 31:26 ignore writes on every alias and always read as 0.
- R9: The word updates on the edge that takes the write. `blk_rst_n` takes the new value on the following edge, so it lags the word by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mgmt_rst | input | 1 | Synchronous active-high management-domain reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 2 | Alias index (byte address bits 3:2): 0 load, 1 release, 2 hold in reset, 3 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| blk_rst_n | output | 26 | Active-low reset lines, registered |

## Verification
Each write alias is driven with several patterns: all ones, all zeros, alternating bits, and patterns that partly overlap the current word. Partial overlap shows whether a zero bit keeps its value or is wrongly loaded. The same data is written through alias 0, alias 1 and alias 2 so that their different results tell the three modes apart. Writes of all ones through alias 3, and to the reserved bits, show that those accesses are discarded. A walking single bit shows that each line is mapped to its own bit. The outputs are sampled one cycle after a write and again one cycle later, which confirms the one-cycle output lag.

// File: rtl/rst_alias_pkg.sv
package rst_alias_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_CTL  = 26;
  localparam int ALIAS_W  = 2;

  localparam int IDX_NET_TOP = 0;
  localparam int IDX_MAC0    = 1;
  localparam int IDX_GPCS0   = 5;
  localparam int IDX_HPCS0   = 9;
  localparam int IDX_TXL0    = 17;
  localparam int IDX_RXL0    = 21;
  localparam int IDX_GLUE    = 25;

  typedef enum logic [ALIAS_W-1:0] {
    ALIAS_LOAD    = 2'd0,
    ALIAS_RELEASE = 2'd1,
    ALIAS_HOLD    = 2'd2,
    ALIAS_NONE    = 2'd3
  } alias_e;

  typedef struct packed {
    logic load;
    logic release_;
    logic hold;
    logic rd;
  } strobe_t;
endpackage

// File: rtl/rst_alias_decode.sv
module rst_alias_decode
  import rst_alias_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               wr,
  input  logic [ALIAS_W-1:0] waddr,
  output strobe_t            strb
);
  alias_e alias_q;
  assign alias_q = alias_e'(waddr);

  always_comb begin
    strb          = '0;
    strb.rd       = sel && !wr;
    if (sel && wr) begin
      unique case (alias_q)
        ALIAS_LOAD:    strb.load     = 1'b1;
        ALIAS_RELEASE: strb.release_ = 1'b1;
        ALIAS_HOLD:    strb.hold     = 1'b1;
        default:       ;
      endcase
    end
  end

  AST_ONE_WRITE_MODE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.load, strb.release_, strb.hold})); // R6
endmodule

// File: rtl/rst_ctl_bit.sv
module rst_ctl_bit (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic release_,
  input  logic hold,
  input  logic d,
  output logic q,
  output logic rst_n_o
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (load)                q_nxt = d;
    else if (release_ && d)  q_nxt = 1'b1;
    else if (hold && d)      q_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= 1'b0;
      rst_n_o <= 1'b0;
    end else begin
      q       <= q_nxt;
      rst_n_o <= q;
    end
  end

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d))); // R3
  AST_RELEASE_SETS: assert property (@(posedge clk) disable iff (rst)
    (release_ && d) |=> q); // R4
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (hold && d) |=> !q); // R5
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    ((release_ || hold) && !d) |=> $stable(q)); // R4
endmodule

// File: rtl/rst_alias_ctrl.sv
module rst_alias_ctrl
  import rst_alias_pkg::*;
#(
  parameter int N_CTL  = NUM_CTL,
  parameter int WORD_W = DATA_W
) (
  input  logic               clk,
  input  logic               mgmt_rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ALIAS_W-1:0] bus_waddr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic [N_CTL-1:0]   blk_rst_n
);
  localparam int RSV_W = WORD_W - N_CTL;

  strobe_t          strb;
  logic [N_CTL-1:0] state;
  logic             unused_rsv_wdata;

  assign unused_rsv_wdata = ^bus_wdata[WORD_W-1:N_CTL];

  rst_alias_decode u_dec (
    .clk   (clk),
    .rst   (mgmt_rst),
    .sel   (bus_sel),
    .wr    (bus_wr),
    .waddr (bus_waddr),
    .strb  (strb)
  );

  for (genvar i = 0; i < N_CTL; i++) begin : g_bit
    rst_ctl_bit u_bit (
      .clk      (clk),
      .rst      (mgmt_rst),
      .load     (strb.load),
      .release_ (strb.release_),
      .hold     (strb.hold),
      .d        (bus_wdata[i]),
      .q        (state[i]),
      .rst_n_o  (blk_rst_n[i])
    );
  end

  always_ff @(posedge clk) begin
    if (mgmt_rst)     bus_rdata <= '0;
    else if (strb.rd) bus_rdata <= {{RSV_W{1'b0}}, state};
  end

  AST_IGNORED_ALIAS: assert property (@(posedge clk) disable iff (mgmt_rst)
    (bus_sel && bus_wr && bus_waddr == ALIAS_NONE) |=> $stable(state)); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    mgmt_rst |=> (blk_rst_n == '0 && state == '0)); // R1
endmodule

// File: tb/rst_alias_ctrl_tb.sv
module rst_alias_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 26;

  logic        clk = 1'b0;
  logic        mgmt_rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] blk_rst_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [NC-1:0] exp_st = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_alias_ctrl u_dut (
    .clk(clk), .mgmt_rst(mgmt_rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .blk_rst_n(blk_rst_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    case (a)
      2'd0: exp_st = d[NC-1:0];
      2'd1: exp_st = exp_st | d[NC-1:0];
      2'd2: exp_st = exp_st & ~d[NC-1:0];
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] r);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    r = bus_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] r;
    bus_read(2'd0, r);
    chk({tag, " read"}, r, {6'b0, exp_st});
    chk({tag, " lines"}, {6'b0, blk_rst_n}, {6'b0, exp_st});
  endtask

  task automatic t_reset;
    logic [31:0] r;
    chk("R1 lines in reset", {6'b0, blk_rst_n}, 32'h0);
    bus_read(2'd1, r);
    chk("R1 read after reset", r, 32'h0);
  endtask

  task automatic t_load;
    bus_write(2'd0, 32'h03FF_FFFF); check_all("R3 load ones");
    bus_write(2'd0, 32'h0155_5555); check_all("R3 load alternating");
    bus_write(2'd0, 32'h0000_0000); check_all("R3 load zeros");
  endtask

  task automatic t_release;
    bus_write(2'd0, 32'h0000_00F0);
    bus_write(2'd1, 32'h0000_0F00); check_all("R4 release adds");
    bus_write(2'd1, 32'h0000_0000); check_all("R4 zeros keep");
    bus_write(2'd1, 32'h0000_0110); check_all("R4 overlap");
  endtask

  task automatic t_hold;
    bus_write(2'd0, 32'h03FF_FFFF);
    bus_write(2'd2, 32'h0000_000F); check_all("R5 hold clears");
    bus_write(2'd2, 32'h0000_0000); check_all("R5 zeros keep");
    bus_write(2'd2, 32'h0200_0018); check_all("R5 overlap");
  endtask

  task automatic t_ignored;
    bus_write(2'd0, 32'h0123_4567);
    bus_write(2'd3, 32'hFFFF_FFFF); check_all("R6 alias3 ones");
    bus_write(2'd3, 32'h0000_0000); check_all("R6 alias3 zeros");
  endtask

  task automatic t_reserved;
    logic [31:0] r;
    bus_write(2'd0, 32'hFC00_0000); check_all("R8 load reserved");
    bus_write(2'd1, 32'hFC00_0001);
    for (int a = 0; a < 4; a++) begin
      bus_read(a[1:0], r);
      chk("R8 reserved zero / R2 alias read", r, {6'b0, exp_st});
    end
  endtask

  task automatic t_map;
    for (int i = 0; i < NC; i++) begin
      bus_write(2'd0, 32'h1 << i);
      @(negedge clk);
      chk("R7 single line", {6'b0, blk_rst_n}, 32'h1 << i);
    end
  endtask

  task automatic t_timing;
    logic [31:0] r;
    bus_write(2'd0, 32'h0000_0000);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = 2'd1; bus_wdata = 32'h0000_0003;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = 2'd2; bus_wdata = '0;
    exp_st = 26'h3;
    chk("R9 lines lag one cycle", {6'b0, blk_rst_n}, 32'h0);
    @(negedge clk);
    bus_sel = 1'b0;
    r = bus_rdata;
    chk("R2 read sees new word", r, 32'h3);
    chk("R9 lines after lag", {6'b0, blk_rst_n}, 32'h3);
  endtask

  task automatic t_rereset;
    bus_write(2'd0, 32'h03FF_FFFF);
    @(negedge clk); mgmt_rst = 1'b1;
    @(negedge clk); mgmt_rst = 1'b0;
    exp_st = '0;
    chk("R1 re-reset lines", {6'b0, blk_rst_n}, 32'h0);
    check_all("R1 re-reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    mgmt_rst = 1'b0;
    t_reset();
    t_load();
    t_release();
    t_hold();
    t_ignored();
    t_reserved();
    t_map();
    t_timing();
    t_rereset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule